// File: doc/BRIEF.md
# Load-Use Hazard Interlock Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline. It inspects the source register numbers of the instruction being decoded, together with the instruction currently in execute. It raises a stall only when the instruction in execute is a load whose result the decode instruction needs as an execute-stage operand. Forwarding cannot supply that value in time, because the loaded data only exists at the end of the memory stage.

On such a hazard the unit clears the program counter write enable and the fetch/decode register write enable. The same instruction is therefore fetched and decoded again on the next cycle. It also tells the decode/execute register to load a bubble, an operation that does nothing. Stages past execute carry on as usual. Once the load has moved into the memory stage, the dependence is covered by forwarding and the stall ends. A load-use pair therefore costs exactly one cycle.

The unit is purely combinational and holds no state; the clock and reset inputs exist only to sample the bound property checker. Ordinary ALU producers, writes to register zero, empty execute slots and unread source fields never cause a stall. A store whose only dependence on the load is its data operand does not stall either, because the memory-stage bypass delivers that value.

Top module: `ldu_interlock`

## Requirements
- R1: When execute holds a valid load with write enable set and a nonzero destination equal to the decode first source (rs), and decode reads rs, then in the same cycle pc_we_o=0, fd_we_o=0 and de_bubble_o=1.
- R2: When the same producer conditions hold for the second source (rt), rt is read and is not marked as store data only (dec_rt_st_i=0), the unit stalls the same way as in R1.
- R3: A producer destination of register 0 never causes a stall.
- R4: No stall occurs if the execute instruction is invalid, is not a load, or has its write enable clear.
- R5: A source whose read flag is 0 never causes a stall, whatever its register number.
- R6: When dec_rt_st_i=1, a match on rt alone does not stall. A match on rs by the same store does stall.
- R7: With no hazard, pc_we_o=1, fd_we_o=1 and de_bubble_o=0.
- R8: In a pipeline built around the unit, a load directly followed by a dependent instruction costs exactly one stall cycle. The bubble appears in the cycle in which the consumer first sits in decode.
- R9: pc_we_o and fd_we_o are always equal, and always the inverse of de_bubble_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used only to sample the property checker |
| rst_ni | input | 1 | Active-low asynchronous reset; disables the checker |
| dec_rs_i | input | AW | First source register number of the decode instruction |
| dec_rt_i | input | AW | Second source register number of the decode instruction |
| dec_rs_rd_i | input | 1 | Decode instruction reads rs |
| dec_rt_rd_i | input | 1 | Decode instruction reads rt |
| dec_rt_st_i | input | 1 | rt is used only as store data |
| ex_rd_i | input | AW | Destination register of the execute instruction |
| ex_we_i | input | 1 | Execute instruction writes the register file |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_valid_i | input | 1 | Execute slot holds a real instruction |
| pc_we_o | output | 1 | Program counter update enable |
| fd_we_o | output | 1 | Fetch/decode register update enable |
| de_bubble_o | output | 1 | Load a no-op into the decode/execute register |

## Verification
The properties assume that the decode and execute fields are stable between clock edges and that register numbers fit within AW bits. They make no assumption about the order in which instructions arrive, so any combination of the inputs is legal. The bench drives the inputs from a small behavioural pipeline that moves instructions from decode to execute. Each instruction pair therefore meets the unit in the same sequence a real pipeline would produce: the producer is first in decode, then in execute, with the consumer behind it. Because the pipeline is advanced by the bench's own expected stall, the inputs are held for whole cycles and change only at falling edges.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_RS  = 0;
  localparam int unsigned SRC_RT  = 1;
endpackage

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          src_rd_i,
  input  logic          late_ok_i,   // value first needed in memory stage
  input  logic [AW-1:0] prod_rd_i,
  input  logic          prod_live_i,
  output logic          hit_o
);
  logic nonzero;
  assign nonzero = |prod_rd_i;
  assign hit_o   = prod_live_i & nonzero & src_rd_i & ~late_ok_i & (src_i == prod_rd_i);
endmodule

// File: rtl/ldu_stall_ctl.sv
module ldu_stall_ctl #(
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0] hit_i,
  output logic            pc_we_o,
  output logic            fd_we_o,
  output logic            bubble_o
);
  logic stall;
  assign stall    = |hit_i;
  assign pc_we_o  = ~stall;
  assign fd_we_o  = ~stall;
  assign bubble_o = stall;
endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock #(
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] dec_rs_i,
  input  logic [AW-1:0] dec_rt_i,
  input  logic          dec_rs_rd_i,
  input  logic          dec_rt_rd_i,
  input  logic          dec_rt_st_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic          ex_valid_i,
  output logic          pc_we_o,
  output logic          fd_we_o,
  output logic          de_bubble_o
);
  import ldu_pkg::*;

  logic                  prod_live;
  logic [AW-1:0]         src   [NUM_SRC];
  logic [NUM_SRC-1:0]    src_rd;
  logic [NUM_SRC-1:0]    late_ok;
  logic [NUM_SRC-1:0]    hit;

  // only a load still in execute leaves a gap forwarding cannot close
  assign prod_live = ex_valid_i & ex_we_i & ex_load_i;

  assign src[SRC_RS]     = dec_rs_i;
  assign src[SRC_RT]     = dec_rt_i;
  assign src_rd[SRC_RS]  = dec_rs_rd_i;
  assign src_rd[SRC_RT]  = dec_rt_rd_i;
  assign late_ok[SRC_RS] = 1'b0;
  assign late_ok[SRC_RT] = dec_rt_st_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ldu_src_cmp #(.AW(AW)) u_cmp (
      .src_i       (src[g]),
      .src_rd_i    (src_rd[g]),
      .late_ok_i   (late_ok[g]),
      .prod_rd_i   (ex_rd_i),
      .prod_live_i (prod_live),
      .hit_o       (hit[g])
    );
  end

  ldu_stall_ctl #(.NSRC(NUM_SRC)) u_ctl (
    .hit_i    (hit),
    .pc_we_o  (pc_we_o),
    .fd_we_o  (fd_we_o),
    .bubble_o (de_bubble_o)
  );
endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] dec_rs_i,
  input logic [AW-1:0] dec_rt_i,
  input logic          dec_rs_rd_i,
  input logic          dec_rt_rd_i,
  input logic          dec_rt_st_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic          ex_valid_i,
  input logic          pc_we_o,
  input logic          fd_we_o,
  input logic          de_bubble_o
);
  logic live;
  assign live = ex_valid_i && ex_we_i && ex_load_i && (ex_rd_i != '0);

  AST_RS_LOAD_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && dec_rs_rd_i && dec_rs_i == ex_rd_i) |-> (de_bubble_o && !pc_we_o)); // R1
  AST_RT_LOAD_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && dec_rt_rd_i && !dec_rt_st_i && dec_rt_i == ex_rd_i) |-> (de_bubble_o && !fd_we_o)); // R2
  AST_ZERO_DEST_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0) |-> !de_bubble_o); // R3
  AST_NO_LOAD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ex_valid_i || !ex_load_i || !ex_we_i) |-> (pc_we_o && fd_we_o)); // R4
  AST_UNREAD_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_rs_rd_i && !dec_rt_rd_i) |-> !de_bubble_o); // R5
  AST_STORE_DATA_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rt_st_i && !(dec_rs_rd_i && dec_rs_i == ex_rd_i)) |-> !de_bubble_o); // R6
  AST_ENABLES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o == fd_we_o) && (pc_we_o != de_bubble_o)); // R9
  AST_STALL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_bubble_o |-> live); // R7
endmodule

bind ldu_interlock ldu_interlock_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_rs_i    (dec_rs_i),
  .dec_rt_i    (dec_rt_i),
  .dec_rs_rd_i (dec_rs_rd_i),
  .dec_rt_rd_i (dec_rt_rd_i),
  .dec_rt_st_i (dec_rt_st_i),
  .ex_rd_i     (ex_rd_i),
  .ex_we_i     (ex_we_i),
  .ex_load_i   (ex_load_i),
  .ex_valid_i  (ex_valid_i),
  .pc_we_o     (pc_we_o),
  .fd_we_o     (fd_we_o),
  .de_bubble_o (de_bubble_o)
);

// File: tb/ldu_interlock_tb.sv
module ldu_interlock_tb;
  localparam int unsigned AW = 5;

  typedef struct {
    logic [AW-1:0] rs, rt, rd;
    logic rs_rd, rt_rd, st, we, ld, vld;
  } instr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] dec_rs, dec_rt, ex_rd;
  logic dec_rs_rd, dec_rt_rd, dec_rt_st, ex_we, ex_load, ex_valid;
  logic pc_we, fd_we, bubble;

  int errors = 0;
  int checks = 0;
  int stalls = 0;
  int first_stall = -1;

  instr_t prog[$];
  instr_t dec_q, ex_q;

  always #4 clk = ~clk;

  ldu_interlock #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_rs_i(dec_rs), .dec_rt_i(dec_rt), .dec_rs_rd_i(dec_rs_rd), .dec_rt_rd_i(dec_rt_rd),
    .dec_rt_st_i(dec_rt_st), .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
    .ex_valid_i(ex_valid), .pc_we_o(pc_we), .fd_we_o(fd_we), .de_bubble_o(bubble)
  );

  function automatic instr_t nop();
    instr_t n;
    n.rs = '0; n.rt = '0; n.rd = '0;
    n.rs_rd = 0; n.rt_rd = 0; n.st = 0; n.we = 0; n.ld = 0; n.vld = 0;
    return n;
  endfunction

  function automatic instr_t mk(int rs, int rt, int rd, bit rsr, bit rtr, bit st, bit we, bit ld, bit vld);
    instr_t n;
    n.rs = AW'(rs); n.rt = AW'(rt); n.rd = AW'(rd);
    n.rs_rd = rsr; n.rt_rd = rtr; n.st = st; n.we = we; n.ld = ld; n.vld = vld;
    return n;
  endfunction

  // reference: stall only when a live load's nonzero result is needed in execute
  function automatic bit ref_stall(instr_t d, instr_t e);
    bit prod;
    prod = e.vld && e.we && e.ld && (e.rd != 0);
    if (!prod) return 0;
    if (d.rs_rd && d.rs == e.rd) return 1;
    if (d.rt_rd && !d.st && d.rt == e.rd) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int idx, string req);
    bit exp;
    dec_rs = dec_q.rs; dec_rt = dec_q.rt; dec_rs_rd = dec_q.rs_rd;
    dec_rt_rd = dec_q.rt_rd; dec_rt_st = dec_q.st;
    ex_rd = ex_q.rd; ex_we = ex_q.we; ex_load = ex_q.ld; ex_valid = ex_q.vld;
    #1;
    exp = ref_stall(dec_q, ex_q);
    check({req, " bubble"}, int'(bubble), int'(exp));
    check({req, " R9 pc_we"}, int'(pc_we), int'(!exp));
    check({req, " R9 fd_we"}, int'(fd_we), int'(!exp));
    if (exp) begin
      stalls++;
      if (first_stall < 0) first_stall = idx;
    end
    @(posedge clk);
    if (exp) ex_q = nop();
    else begin
      ex_q = dec_q;
      dec_q = (prog.size() > 0) ? prog.pop_front() : nop();
    end
    @(negedge clk);
  endtask

  // producer then consumer; bubble expected at step 2 when a stall is due (R8)
  task automatic run_pair(string req, instr_t p, instr_t c, int exp_stalls);
    prog.delete();
    prog.push_back(p); prog.push_back(c); prog.push_back(nop()); prog.push_back(nop());
    dec_q = nop(); ex_q = nop();
    stalls = 0; first_stall = -1;
    for (int i = 0; i < 7; i++) step(i, req);
    check({req, " R8 stall count"}, stalls, exp_stalls);
    if (exp_stalls == 1) check({req, " R8 bubble step"}, first_stall, 2);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    dec_q = nop(); ex_q = nop();
    dec_rs = '0; dec_rt = '0; dec_rs_rd = 0; dec_rt_rd = 0; dec_rt_st = 0;
    ex_rd = '0; ex_we = 0; ex_load = 0; ex_valid = 0;
    #2;
    check("R7 reset pc_we", int'(pc_we), 1);
    check("R7 reset bubble", int'(bubble), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // load r5 then use
    run_pair("R1 rs use", mk(2,0,5,1,0,0,1,1,1), mk(5,7,3,1,1,0,1,0,1), 1);
    run_pair("R2 rt use", mk(2,0,5,1,0,0,1,1,1), mk(6,5,3,1,1,0,1,0,1), 1);
    run_pair("R3 dest zero", mk(2,0,0,1,0,0,1,1,1), mk(0,0,3,1,1,0,1,0,1), 0);
    run_pair("R4 alu producer", mk(2,0,5,1,0,0,1,0,1), mk(5,5,3,1,1,0,1,0,1), 0);
    run_pair("R4 invalid load", mk(2,0,5,1,0,0,1,1,0), mk(5,5,3,1,1,0,1,0,1), 0);
    run_pair("R4 no write", mk(2,0,5,1,0,0,0,1,1), mk(5,5,3,1,1,0,1,0,1), 0);
    run_pair("R5 unread rt", mk(2,0,5,1,0,0,1,1,1), mk(6,5,3,1,0,0,1,0,1), 0);
    run_pair("R5 unread rs", mk(2,0,5,1,0,0,1,1,1), mk(5,6,3,0,1,0,1,0,1), 0);
    run_pair("R6 store data", mk(2,0,5,1,0,0,1,1,1), mk(6,5,0,1,1,1,0,0,1), 0);
    run_pair("R6 store addr", mk(2,0,5,1,0,0,1,1,1), mk(5,9,0,1,1,1,0,0,1), 1);
    run_pair("R7 independent", mk(2,0,5,1,0,0,1,1,1), mk(6,7,3,1,1,0,1,0,1), 0);
    run_pair("R8 both srcs", mk(2,0,31,1,0,0,1,1,1), mk(31,31,4,1,1,0,1,0,1), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule